// File: doc/BRIEF.md
# DMA channel control and sequencer

This block is the control side of one DMA channel. Software configures it through a small 8-bit register bus: one control register with enable, channel reset, repeat, software request, single-shot and a two-bit burst code, a block byte count and a repeat count. Once the channel is enabled, a request (the software request bit or a pulse on `trig_in`) starts data movement. Each burst reads bytes from a source over a request/acknowledge handshake into an internal buffer, then writes them to the destination over a second handshake. The sequencer counts bytes within a block and counts blocks for repeat mode.

Without single-shot, one request moves a whole block as back-to-back bursts. With single-shot, each request moves one burst. When the whole transaction is over, the enable bit clears itself and a completion pulse is raised. Disabling the channel mid-transfer stops any further reads. The busy status stays high while the bytes already fetched are written out, and then an abort pulse is raised. Channel arbitration, address generation and interrupt logic sit outside this block.

Top module: `dma_chan_ctl`

## Requirements
- R1: Register map: offset 0 is control (bit 7 enable, bit 6 channel reset, bit 5 repeat, bit 4 software request, bit 3 always reads 0, bit 2 single-shot, bits 1:0 burst code); offsets 1 and 2 are the low and high bytes of the block count; offset 3 is the repeat count. After reset all four read 0x00 and `ch_busy` is 0.
- R2: Burst code k gives a burst of 2^k bytes (1, 2, 4, 8). In single-shot mode each start moves min(burst, bytes left in block) and then waits for the next request.
- R3: Without single-shot, one start moves the whole block. A block count of 0 means 2^CNT_W bytes.
- R4: The software request bit is taken only when the same write sets enable, and it reads 0 once the transfer starts. A one-cycle `trig_in` pulse starts a transfer just as the request bit does, while the channel is enabled and idle.
- R5: When the last byte of the transaction is written, enable reads 0, `ch_busy` falls and `done_pulse` is high for exactly one cycle.
- R6: With repeat set and repeat count N > 0, the transaction is N blocks. Each block after the first needs its own request. The count decrements at each block start, and the repeat bit reads 0 as soon as the last block starts. A repeat count of 0 repeats without end.
- R7: Writing enable to 0 during a transfer stops new reads. `ch_busy` stays high until every byte read has been written, then `abort_pulse` is raised and no `done_pulse` follows.
- R8: A write with the channel-reset bit set is ignored while `ch_busy` is 1. When accepted, the bit reads 1 for one cycle and then every register reads 0x00.
- R9: Writes to single-shot and to the burst code are ignored while `ch_busy` is 1.
- R10: Bytes are written in the order they were read. Each read and write request is held, with write data stable, until acknowledged, and read and write requests are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| trig_in | input | 1 | Transfer trigger pulse |
| mem_rd_req | output | 1 | Source read request, held until acknowledged |
| mem_rd_ack | input | 1 | Source read acknowledge, data valid |
| mem_rd_data | input | 8 | Source read data |
| mem_wr_req | output | 1 | Destination write request, held until acknowledged |
| mem_wr_ack | input | 1 | Destination write acknowledge |
| mem_wr_data | output | 8 | Destination write data |
| ch_busy | output | 1 | Channel-enabled status, includes buffer drain |
| done_pulse | output | 1 | One-cycle transaction completion |
| abort_pulse | output | 1 | One-cycle abort completion after drain |

## Verification
The assertions assume that memory acknowledges arrive only while the matching request is high, one byte per acknowledge cycle, and that `trig_in` is a single-cycle pulse. The bench memory model raises an acknowledge only on a half-cycle where it sees the request and did not acknowledge the previous cycle. It counts every accepted byte, so the stimulus never offers a stray acknowledge. Triggers are sent only after the previous burst has had time to drain, so no request arrives while a burst is in flight.

// File: rtl/dma_ctl_pkg.sv
// Shared definitions for the DMA channel controller: register offsets,
// control bit positions and the sequencer state type.
package dma_ctl_pkg;
    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] OFS_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] OFS_CNTL = 2'd1;
    localparam logic [REG_AW-1:0] OFS_CNTH = 2'd2;
    localparam logic [REG_AW-1:0] OFS_REPC = 2'd3;

    localparam int BIT_EN   = 7;
    localparam int BIT_SRST = 6;
    localparam int BIT_RPT  = 5;
    localparam int BIT_REQ  = 4;
    localparam int BIT_SGL  = 2;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dma_burst_buf.sv
// Burst buffer: a small FIFO holding bytes between the read and write
// phases of a burst. Assumes DEPTH is a power of two and that push is
// never raised when full nor pop when empty (the sequencer guarantees it).
module dma_burst_buf #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [$clog2(DEPTH):0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wp, rp;

    // Storage write on push; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) store[wp] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout = store[rp];
endmodule

// File: rtl/dma_ctl_regs.sv
// Channel register file: control, block count and repeat count.
// Applies the write-ignore rules that depend on the busy status and
// takes self-clear and decrement strobes from the sequencer, which win
// over a software write in the same cycle.
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int REP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              ch_on,
    input  logic              clr_en,
    input  logic              clr_req,
    input  logic              clr_rpt,
    input  logic              dec_rep,
    output logic              en,
    output logic              rpt,
    output logic              req,
    output logic              sgl,
    output logic [1:0]        bcode,
    output logic [15:0]       blkcnt,
    output logic [REP_W-1:0]  repcnt,
    output logic              srst
);
    // Register updates: reset, software writes, then hardware strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            en     <= 1'b0;
            rpt    <= 1'b0;
            req    <= 1'b0;
            sgl    <= 1'b0;
            bcode  <= 2'd0;
            blkcnt <= '0;
            repcnt <= '0;
            srst   <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    OFS_CTRL: begin
                        if (wdata[BIT_SRST]) begin
                            if (!ch_on) srst <= 1'b1;
                        end else begin
                            en  <= wdata[BIT_EN];
                            rpt <= wdata[BIT_RPT];
                            req <= wdata[BIT_REQ] & wdata[BIT_EN];
                            if (!ch_on) begin
                                sgl   <= wdata[BIT_SGL];
                                bcode <= wdata[1:0];
                            end
                        end
                    end
                    OFS_CNTL: blkcnt[7:0]  <= wdata;
                    OFS_CNTH: blkcnt[15:8] <= wdata;
                    default:  repcnt       <= REP_W'(wdata);
                endcase
            end
            if (clr_en)  en     <= 1'b0;
            if (clr_req) req    <= 1'b0;
            if (clr_rpt) rpt    <= 1'b0;
            if (dec_rep) repcnt <= repcnt - 1'b1;
        end
    end

    // Read multiplexer; bit 3 of control is hard-wired to zero.
    always_comb begin
        case (addr)
            OFS_CTRL: rdata = {en, srst, rpt, req, 1'b0, sgl, bcode};
            OFS_CNTL: rdata = blkcnt[7:0];
            OFS_CNTH: rdata = blkcnt[15:8];
            default:  rdata = 8'(repcnt);
        endcase
    end
endmodule

// File: rtl/dma_seq.sv
// Transfer sequencer: starts bursts on request, runs the read phase into
// the buffer and the write phase out of it, tracks bytes left in the
// block and block repeat, and produces busy, completion and abort.
// Assumes acknowledges only arrive while the matching request is high.
module dma_seq
    import dma_ctl_pkg::*;
#(
    parameter int BUF_DEPTH = 8,
    parameter int CNT_W     = 16,
    parameter int REP_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       srst,
    input  logic                       en,
    input  logic                       sgl,
    input  logic [1:0]                 bcode,
    input  logic                       rpt,
    input  logic [REP_W-1:0]           repcnt,
    input  logic [CNT_W-1:0]           blkcnt,
    input  logic                       req,
    input  logic                       trig,
    input  logic                       rd_ack,
    input  logic                       wr_ack,
    input  logic [$clog2(BUF_DEPTH):0] buf_cnt,
    output logic                       rd_req,
    output logic                       wr_req,
    output logic                       push,
    output logic                       pop,
    output logic                       ch_on,
    output logic                       clr_en,
    output logic                       clr_req,
    output logic                       clr_rpt,
    output logic                       dec_rep,
    output logic                       done_pulse,
    output logic                       abort_pulse
);
    localparam int LEFT_W = CNT_W + 1;
    localparam int BW     = $clog2(BUF_DEPTH) + 1;

    seq_state_t        state;
    logic [LEFT_W-1:0] blk_left, block_size, left_eff, cap, first_n, rem_after, next_n;
    logic [BW-1:0]     rd_left, got_cnt;
    logic              blk_open, last_blk;
    logic              start_req, new_block, burst_end, done_now, abort_now;

    // Burst sizing and event decode.
    always_comb begin
        block_size = (blkcnt == '0) ? (LEFT_W'(1) << CNT_W) : {1'b0, blkcnt};
        cap        = LEFT_W'(1) << bcode;
        if (cap > LEFT_W'(BUF_DEPTH)) cap = LEFT_W'(BUF_DEPTH);
        left_eff   = blk_open ? blk_left : block_size;
        first_n    = (left_eff < cap) ? left_eff : cap;
        rem_after  = blk_left - LEFT_W'(got_cnt);
        next_n     = (rem_after < cap) ? rem_after : cap;
        start_req  = (state == SQ_IDLE) && en && ch_on && (req || trig);
        new_block  = start_req && !blk_open;
        burst_end  = (state == SQ_WRITE) && wr_ack && (buf_cnt == BW'(1));
        done_now   = burst_end && en && (rem_after == '0) && last_blk;
        abort_now  = (burst_end && !en) || ((state == SQ_IDLE) && ch_on && !en);
    end

    assign rd_req  = (state == SQ_READ);
    assign wr_req  = (state == SQ_WRITE) && (buf_cnt != '0);
    assign push    = rd_req && rd_ack;
    assign pop     = wr_req && wr_ack;
    assign clr_en  = done_now;
    assign clr_req = start_req;
    assign clr_rpt = new_block && rpt && (repcnt == REP_W'(1));
    assign dec_rep = new_block && rpt && (repcnt != '0);

    // Phase control, byte accounting and block tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            state    <= SQ_IDLE;
            blk_left <= '0;
            rd_left  <= '0;
            got_cnt  <= '0;
            blk_open <= 1'b0;
            last_blk <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_req) begin
                        state   <= SQ_READ;
                        rd_left <= BW'(first_n);
                        got_cnt <= '0;
                        if (!blk_open) begin
                            blk_left <= block_size;
                            blk_open <= 1'b1;
                            last_blk <= rpt ? (repcnt == REP_W'(1)) : 1'b1;
                        end
                    end else if (abort_now) begin
                        blk_open <= 1'b0;
                    end
                end
                SQ_READ: begin
                    if (rd_ack) begin
                        got_cnt <= got_cnt + 1'b1;
                        rd_left <= rd_left - 1'b1;
                        if (rd_left == BW'(1) || !en) state <= SQ_WRITE;
                    end
                end
                default: begin
                    if (burst_end) begin
                        blk_left <= rem_after;
                        got_cnt  <= '0;
                        if (!en || rem_after == '0) begin
                            state    <= SQ_IDLE;
                            blk_open <= 1'b0;
                        end else if (sgl) begin
                            state <= SQ_IDLE;
                        end else begin
                            state   <= SQ_READ;
                            rd_left <= BW'(next_n);
                        end
                    end
                end
            endcase
        end
    end

    // Channel status and one-cycle event outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            ch_on       <= 1'b0;
            done_pulse  <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            done_pulse  <= done_now;
            abort_pulse <= abort_now;
            if (done_now || abort_now) ch_on <= 1'b0;
            else if (en)               ch_on <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_chan_ctl.sv
// DMA channel control top: register file, sequencer and burst buffer.
// Assumes BUF_DEPTH is a power of two of at least 8 so the largest burst
// fits, and CNT_W is at most 16 (the count is exposed as two bytes).
module dma_chan_ctl
    import dma_ctl_pkg::*;
#(
    parameter int BUF_DEPTH = 8,
    parameter int CNT_W     = 16,
    parameter int REP_W     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       trig_in,
    output logic       mem_rd_req,
    input  logic       mem_rd_ack,
    input  logic [7:0] mem_rd_data,
    output logic       mem_wr_req,
    input  logic       mem_wr_ack,
    output logic [7:0] mem_wr_data,
    output logic       ch_busy,
    output logic       done_pulse,
    output logic       abort_pulse
);
    localparam int BCW = $clog2(BUF_DEPTH) + 1;

    logic             en_w, rpt_w, req_w, sgl_w, srst_w;
    logic [1:0]       bl_w;
    logic [15:0]      blkcnt_w;
    logic [REP_W-1:0] repcnt_w;
    logic             clr_en_w, clr_req_w, clr_rpt_w, dec_rep_w;
    logic             push_w, pop_w, ch_on_w;
    logic [BCW-1:0]   buf_cnt_w;

    dma_ctl_regs #(.REP_W(REP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ch_on(ch_on_w),
        .clr_en(clr_en_w), .clr_req(clr_req_w), .clr_rpt(clr_rpt_w),
        .dec_rep(dec_rep_w), .en(en_w), .rpt(rpt_w), .req(req_w),
        .sgl(sgl_w), .bcode(bl_w), .blkcnt(blkcnt_w), .repcnt(repcnt_w),
        .srst(srst_w)
    );

    dma_seq #(.BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W), .REP_W(REP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .srst(srst_w), .en(en_w), .sgl(sgl_w),
        .bcode(bl_w), .rpt(rpt_w), .repcnt(repcnt_w),
        .blkcnt(blkcnt_w[CNT_W-1:0]), .req(req_w), .trig(trig_in),
        .rd_ack(mem_rd_ack), .wr_ack(mem_wr_ack), .buf_cnt(buf_cnt_w),
        .rd_req(mem_rd_req), .wr_req(mem_wr_req), .push(push_w), .pop(pop_w),
        .ch_on(ch_on_w), .clr_en(clr_en_w), .clr_req(clr_req_w),
        .clr_rpt(clr_rpt_w), .dec_rep(dec_rep_w), .done_pulse(done_pulse),
        .abort_pulse(abort_pulse)
    );

    dma_burst_buf #(.DEPTH(BUF_DEPTH), .DATA_W(8)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(push_w), .din(mem_rd_data),
        .pop(pop_w), .dout(mem_wr_data), .count(buf_cnt_w)
    );

    assign ch_busy = ch_on_w;
endmodule

// File: rtl/dma_chan_ctl_chk.sv
// Property checker for dma_chan_ctl, attached by bind. Assumes memory
// acknowledges only arrive while the matching request is high.
module dma_chan_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_en,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       mem_rd_req,
    input logic       mem_rd_ack,
    input logic       mem_wr_req,
    input logic       mem_wr_ack,
    input logic [7:0] mem_wr_data,
    input logic       ch_busy,
    input logic       done_pulse,
    input logic       abort_pulse,
    input logic       srst,
    input logic [1:0] bl,
    input logic       sgl
);
    // R5
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !ch_busy);
    // R7
    abort_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (!mem_wr_req && !mem_rd_req && !ch_busy && !done_pulse));
    // R8
    srst_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 2'd0 && reg_wdata[6] && ch_busy) |=> !srst);
    // R8
    srst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !srst);
    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_busy |=> (!ch_busy || ($stable(bl) && $stable(sgl))));
    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> mem_rd_req);
    // R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_data)));
    // R10
    no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));
endmodule

bind dma_chan_ctl dma_chan_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack),
    .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack),
    .mem_wr_data(mem_wr_data), .ch_busy(ch_busy), .done_pulse(done_pulse),
    .abort_pulse(abort_pulse), .srst(srst_w), .bl(bl_w), .sgl(sgl_w)
);

// File: tb/tb_dma_chan_ctl.sv
// Bench: sweeps burst code, single-shot and block size over a 10-bit
// count configuration, then repeat, abort, channel reset and ignore cases.
module tb_dma_chan_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       trig_in = 1'b0;
    logic       mem_rd_req, mem_wr_req;
    logic       mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
    logic [7:0] mem_rd_data = 8'd0;
    logic [7:0] mem_wr_data;
    logic       ch_busy, done_pulse, abort_pulse;

    int total = 0, bad = 0;
    int rd_cnt = 0, wr_cnt = 0, n_done = 0, n_abort = 0;
    logic [7:0] rd_seq = 8'd0, wr_seq = 8'd0;
    bit finished = 0;

    dma_chan_ctl #(.CNT_W(10)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
        .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
        .mem_wr_ack(mem_wr_ack), .mem_wr_data(mem_wr_data),
        .ch_busy(ch_busy), .done_pulse(done_pulse), .abort_pulse(abort_pulse)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Memory model: alternate-cycle acknowledges, write order check (R10).
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_ack) begin
                rd_seq = rd_seq + 8'd1;
                rd_cnt++;
            end
            mem_rd_ack  = mem_rd_req && !mem_rd_ack;
            mem_rd_data = rd_seq;
            if (mem_wr_req && !mem_wr_ack) begin
                mem_wr_ack = 1'b1;
                check(mem_wr_data == wr_seq, "R10 byte order", mem_wr_data, wr_seq);
                wr_seq = wr_seq + 8'd1;
                wr_cnt++;
            end else begin
                mem_wr_ack = 1'b0;
            end
            if (done_pulse)  n_done++;
            if (abort_pulse) n_abort++;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_done(input int d0, input int lim);
        for (int i = 0; i < lim && n_done == d0; i++) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(150000 * 20);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R10 watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int sizes [5] = '{1, 3, 5, 8, 9};
        int w0, d0, a0, r0, rem, expb;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 8'h00, "R1 reset value", v, 0);
        end
        check(ch_busy == 1'b0, "R1 busy after reset", ch_busy, 0);
        wr(2'd0, 8'h08);
        rd(2'd0, v);
        check(v == 8'h00, "R1 bit3 reads zero", v, 0);

        // R4 request without enable is ignored
        w0 = wr_cnt;
        wr(2'd0, 8'h10);
        rd(2'd0, v);
        check(v == 8'h00, "R4 request needs enable", v, 0);
        idle(20);
        check(wr_cnt == w0, "R4 no transfer without enable", wr_cnt - w0, 0);

        // R2/R3/R5 sweep: burst code x single-shot x block size
        for (int bl = 0; bl < 4; bl++) begin
            for (int sg = 0; sg < 2; sg++) begin
                foreach (sizes[k]) begin
                    wr(2'd1, 8'(sizes[k]));
                    wr(2'd2, 8'd0);
                    w0 = wr_cnt; d0 = n_done;
                    if (sg == 0) begin
                        wr(2'd0, 8'h90 | 8'(bl));
                        wait_done(d0, 400);
                        check(wr_cnt - w0 == sizes[k], "R3 whole block per start",
                              wr_cnt - w0, sizes[k]);
                    end else begin
                        wr(2'd0, 8'h94 | 8'(bl));
                        rem = sizes[k];
                        while (rem > 0) begin
                            r0 = wr_cnt;
                            idle(60);
                            expb = ((1 << bl) < rem) ? (1 << bl) : rem;
                            check(wr_cnt - r0 == expb, "R2 bytes per single-shot start",
                                  wr_cnt - r0, expb);
                            rem -= expb;
                            if (rem > 0) begin
                                rd(2'd0, v);
                                check(v[4] == 1'b0, "R4 request cleared on start", v[4], 0);
                                pulse_trig();
                            end
                        end
                    end
                    idle(4);
                    check(n_done == d0 + 1, "R5 one completion pulse", n_done - d0, 1);
                    rd(2'd0, v);
                    check(v[7] == 1'b0 && ch_busy == 1'b0, "R5 enable auto-clear",
                          {v[7], ch_busy}, 0);
                end
            end
        end

        // R6 repeat with count 3
        wr(2'd3, 8'd3); wr(2'd1, 8'd3);
        w0 = wr_cnt; d0 = n_done;
        wr(2'd0, 8'hB3);
        idle(60);
        rd(2'd0, v);
        check(v == 8'hA3, "R6 repeat held after block 1", v, 8'hA3);
        rd(2'd3, v);
        check(v == 8'd2, "R6 repeat count after block 1", v, 2);
        pulse_trig();
        idle(60);
        rd(2'd3, v);
        check(v == 8'd1 && wr_cnt - w0 == 6, "R6 block 2 done", wr_cnt - w0, 6);
        check(n_done == d0, "R6 no completion before last block", n_done - d0, 0);
        pulse_trig();
        rd(2'd0, v);
        check(v == 8'h83, "R6 repeat cleared at last block start", v, 8'h83);
        idle(60);
        check(wr_cnt - w0 == 9 && n_done == d0 + 1, "R6 three blocks then done",
              wr_cnt - w0, 9);
        rd(2'd0, v);
        check(v == 8'h03, "R6 control after repeat run", v, 8'h03);

        // R6 repeat count zero runs without end
        wr(2'd3, 8'd0); wr(2'd1, 8'd2);
        w0 = wr_cnt; d0 = n_done; a0 = n_abort;
        wr(2'd0, 8'hB1);
        idle(60);
        for (int t = 0; t < 3; t++) begin
            pulse_trig();
            idle(60);
        end
        check(wr_cnt - w0 == 8 && n_done == d0 && ch_busy, "R6 endless repeat",
              wr_cnt - w0, 8);
        wr(2'd0, 8'h00);
        idle(5);
        check(n_abort == a0 + 1 && !ch_busy, "R7 abort between blocks", n_abort - a0, 1);

        // R3 count zero, with R8/R9 ignored writes while busy
        wr(2'd1, 8'd0); wr(2'd2, 8'd0);
        w0 = wr_cnt; d0 = n_done;
        wr(2'd0, 8'h93);
        idle(20);
        wr(2'd0, 8'hC6);
        rd(2'd0, v);
        check(v == 8'h83, "R8 R9 reset/single/burst ignored while busy", v, 8'h83);
        wait_done(d0, 6000);
        check(wr_cnt - w0 == 1024, "R3 count zero is full range", wr_cnt - w0, 1024);

        // R7 abort mid-transfer
        w0 = wr_cnt; d0 = n_done; a0 = n_abort;
        wr(2'd0, 8'h93);
        idle(15);
        wr(2'd0, 8'h03);
        check(ch_busy == 1'b1, "R7 busy held during drain", ch_busy, 1);
        for (int i = 0; i < 100 && ch_busy; i++) @(negedge clk);
        idle(3);
        check(n_abort == a0 + 1, "R7 abort pulse", n_abort - a0, 1);
        check(n_done == d0, "R7 no completion on abort", n_done - d0, 0);
        check(wr_cnt == rd_cnt, "R7 buffer drained", wr_cnt, rd_cnt);
        check(wr_cnt - w0 > 0 && wr_cnt - w0 < 1024, "R7 transfer stopped early",
              wr_cnt - w0, 1);

        // R8 accepted channel reset
        wr(2'd1, 8'h55); wr(2'd3, 8'h07); wr(2'd0, 8'h05);
        rd(2'd0, v);
        check(v == 8'h05, "R9 config written while idle", v, 8'h05);
        wr(2'd0, 8'h40);
        reg_addr = 2'd0;
        #1 v = reg_rdata;
        check(v == 8'h45, "R8 reset bit visible one cycle", v, 8'h45);
        rd(2'd0, v);
        check(v == 8'h00, "R8 control cleared", v, 0);
        rd(2'd1, v);
        check(v == 8'h00, "R8 count cleared", v, 0);
        rd(2'd3, v);
        check(v == 8'h00, "R8 repeat count cleared", v, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule